// File: doc/BRIEF.md
# Reset and Power-Down Sequencer

This block controls the reset and low-power states of a converter-style device. Three things can start a reset: the supply-good inputs, one active-low pin, and a strobe from the serial interface that reports a decoded reset command. The pin has two jobs, and the time it is held low decides which one it does. A short hold resets the device. A very long hold puts the device into power-down, which turns off the oscillator, the reference and the serial interface.

Every reset, whatever its source, sends one pulse that loads the configuration registers with their defaults. The same cycle restarts the conversion cycle. The ready flag then stays low for a wait that depends on the kind of exit. After that wait it rises to tell the serial interface that traffic may start. All counting uses the master clock, which keeps running in every state. The pin passes through a two-flop synchronizer, and every count is taken on the synchronized copy.

Top module: `pwr_rst_seq`

## Requirements
- R1: After the last supply-good input goes high, the internal reset stays high and the ready flag stays low for POR_WAIT + 2 master-clock cycles. That count includes a two-cycle release synchronizer. Then the internal reset drops, the ready flag rises, and exactly one defaults/restart pulse fires.
- R2: When any supply-good input goes low, the internal reset rises and the ready flag drops at once, with no clock edge needed. The full power-on count starts again when all supplies are good.
- R3: When the synchronized pin has been low for at least RST_MIN_LOW (4) cycles and then returns high, one defaults/restart pulse fires. The ready flag stays low for RST_WAIT (8) cycles after the pulse and then rises.
- R4: A low pin pulse shorter than RST_MIN_LOW cycles causes no pulse and no internal reset. The ready flag comes back high once the pin is high again.
- R5: Holding the pin low for PD_LOW cycles drives power-down high, with the internal reset high and the ready flag low. A hold that ends before PD_LOW cycles is treated as a plain reset, following R3.
- R6: When the synchronized pin rises during power-down, power-down falls and the defaults/restart pulse fires in the same cycle. The ready flag rises PD_WAIT cycles after the pulse.
- R7: A reset-command strobe while the device is ready fires a defaults/restart pulse and drops the ready flag in the next cycle. The ready flag rises RST_WAIT cycles after the pulse.
- R8: A reset-command strobe during power-down is ignored. No pulse fires and power-down stays high.
- R9: The defaults-load and conversion-restart outputs are high together, and always for one cycle only.
- R10: The ready flag is high only in the normal operating state, and never while the internal reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock, always running |
| resetPinN | input | 1 | asynchronous active-low reset/power-down pin |
| supplyOk | input | NUM_SUPPLY | supply-good flags, high when each supply is valid |
| cmdResetStb | input | 1 | one-cycle strobe: a reset command was received |
| coreReset | output | 1 | internal reset, active high |
| powerDown | output | 1 | high turns off the oscillator, reference and serial interface |
| loadDefaults | output | 1 | one-cycle pulse: load register defaults |
| convRestart | output | 1 | one-cycle pulse: restart the conversion cycle |
| commReady | output | 1 | high when serial communication may start |

## Verification
The bench builds the block with PD_LOW=64, PD_WAIT=48 and POR_WAIT=32. RST_MIN_LOW and RST_WAIT keep their defaults of 4 and 8. With these values, entering power-down, leaving it and the power-on count each take a few dozen cycles instead of 65536. That lets one short run test the exact ready-wait lengths, the 3- and 4-cycle pulse boundary, and a hold just under the power-down threshold.

// File: rtl/pwr_rst_seq_pkg.sv
package pwr_rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_POR,
    ST_RUN,
    ST_LOW,
    ST_PDOWN,
    ST_WAIT
  } seqState_t;

  typedef enum logic {
    WAIT_SHORT,
    WAIT_LONG
  } waitSel_t;

  // control -> datapath strobes
  typedef struct packed {
    logic     waitLoad;
    waitSel_t waitSel;
  } seqStrobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic pinHigh;
    logic lowAtMin;
    logic lowAtPd;
    logic waitOne;
  } seqStatus_t;

endpackage

// File: rtl/pwr_rst_seq_dp.sv
module pwr_rst_seq_dp
  import pwr_rst_seq_pkg::*;
#(
  parameter int NUM_SUPPLY  = 3,
  parameter int RST_MIN_LOW = 4,
  parameter int PD_LOW      = 65536,
  parameter int RST_WAIT    = 8,
  parameter int PD_WAIT     = 65536,
  parameter int POR_WAIT    = 65536
) (
  input  logic                  clk,
  input  logic                  resetPinN,
  input  logic [NUM_SUPPLY-1:0] supplyOk,
  input  seqStrobe_t            strobe,
  output logic                  porRstN,
  output seqStatus_t            status
);

  localparam int LOW_W    = $clog2(PD_LOW + 1);
  localparam int WAIT_MAX = (POR_WAIT > PD_WAIT)
                            ? ((POR_WAIT > RST_WAIT) ? POR_WAIT : RST_WAIT)
                            : ((PD_WAIT > RST_WAIT) ? PD_WAIT : RST_WAIT);
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  logic              allGood;
  logic [1:0]        porSync;
  logic [1:0]        pinSync;
  logic [LOW_W-1:0]  lowCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitLoadVal;

  assign allGood = &supplyOk;

  // release synchronizer: asserts at once, releases after two edges
  always_ff @(posedge clk or negedge allGood) begin
    if (!allGood) porSync <= 2'b00;
    else          porSync <= {porSync[0], 1'b1};
  end
  assign porRstN = porSync[1];

  // pin synchronizer
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) pinSync <= 2'b11;
    else          pinSync <= {pinSync[0], resetPinN};
  end

  // low-time counter, saturating at the power-down threshold
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                       lowCnt <= '0;
    else if (pinSync[1])                lowCnt <= '0;
    else if (lowCnt != LOW_W'(PD_LOW))  lowCnt <= lowCnt + 1'b1;
  end

  always_comb begin
    waitLoadVal = (strobe.waitSel == WAIT_LONG) ? WAIT_W'(PD_WAIT) : WAIT_W'(RST_WAIT);
  end

  // shared wait counter: power-on count, post-reset and post-power-down waits
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)             waitCnt <= WAIT_W'(POR_WAIT);
    else if (strobe.waitLoad) waitCnt <= waitLoadVal;
    else if (waitCnt != '0)   waitCnt <= waitCnt - 1'b1;
  end

  always_comb begin
    status.pinHigh  = pinSync[1];
    status.lowAtMin = (lowCnt >= LOW_W'(RST_MIN_LOW));
    status.lowAtPd  = (lowCnt == LOW_W'(PD_LOW));
    status.waitOne  = (waitCnt == WAIT_W'(1));
  end

endmodule

// File: rtl/pwr_rst_seq_ctrl.sv
module pwr_rst_seq_ctrl
  import pwr_rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       porRstN,
  input  logic       cmdResetStb,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       coreReset,
  output logic       powerDown,
  output logic       resetPulse,
  output logic       commReady
);

  seqState_t state, stateNext;
  logic      pulseNext;

  always_comb begin
    stateNext      = state;
    pulseNext      = 1'b0;
    strobe.waitLoad = 1'b0;
    strobe.waitSel  = WAIT_SHORT;
    unique case (state)
      ST_POR: begin
        if (status.waitOne) begin
          stateNext = ST_RUN;
          pulseNext = 1'b1;
        end
      end
      ST_RUN: begin
        if (!status.pinHigh) begin
          stateNext = ST_LOW;
        end else if (cmdResetStb) begin
          stateNext       = ST_WAIT;
          pulseNext       = 1'b1;
          strobe.waitLoad = 1'b1;
        end
      end
      ST_LOW: begin
        if (status.lowAtPd) begin
          stateNext = ST_PDOWN;
        end else if (status.pinHigh) begin
          if (status.lowAtMin) begin
            stateNext       = ST_WAIT;
            pulseNext       = 1'b1;
            strobe.waitLoad = 1'b1;
          end else begin
            stateNext = ST_RUN;
          end
        end
      end
      ST_PDOWN: begin
        if (status.pinHigh) begin
          stateNext       = ST_WAIT;
          pulseNext       = 1'b1;
          strobe.waitLoad = 1'b1;
          strobe.waitSel  = WAIT_LONG;
        end
      end
      ST_WAIT: begin
        if (!status.pinHigh) begin
          stateNext = ST_LOW;
        end else if (cmdResetStb) begin
          pulseNext       = 1'b1;
          strobe.waitLoad = 1'b1;
        end else if (status.waitOne) begin
          stateNext = ST_RUN;
        end
      end
      default: stateNext = ST_POR;
    endcase
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      state      <= ST_POR;
      resetPulse <= 1'b0;
    end else begin
      state      <= stateNext;
      resetPulse <= pulseNext;
    end
  end

  always_comb begin
    coreReset = (state == ST_POR) || (state == ST_PDOWN) ||
                ((state == ST_LOW) && status.lowAtMin);
    powerDown = (state == ST_PDOWN);
    commReady = (state == ST_RUN);
  end

endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
  import pwr_rst_seq_pkg::*;
#(
  parameter int NUM_SUPPLY  = 3,
  parameter int RST_MIN_LOW = 4,
  parameter int PD_LOW      = 65536,
  parameter int RST_WAIT    = 8,
  parameter int PD_WAIT     = 65536,
  parameter int POR_WAIT    = 65536
) (
  input  logic                  clk,
  input  logic                  resetPinN,
  input  logic [NUM_SUPPLY-1:0] supplyOk,
  input  logic                  cmdResetStb,
  output logic                  coreReset,
  output logic                  powerDown,
  output logic                  loadDefaults,
  output logic                  convRestart,
  output logic                  commReady
);

  seqStrobe_t strobe;
  seqStatus_t status;
  logic       porRstN;
  logic       resetPulse;

  pwr_rst_seq_dp #(
    .NUM_SUPPLY (NUM_SUPPLY),
    .RST_MIN_LOW(RST_MIN_LOW),
    .PD_LOW     (PD_LOW),
    .RST_WAIT   (RST_WAIT),
    .PD_WAIT    (PD_WAIT),
    .POR_WAIT   (POR_WAIT)
  ) i_dp (
    .clk      (clk),
    .resetPinN(resetPinN),
    .supplyOk (supplyOk),
    .strobe   (strobe),
    .porRstN  (porRstN),
    .status   (status)
  );

  pwr_rst_seq_ctrl i_ctrl (
    .clk        (clk),
    .porRstN    (porRstN),
    .cmdResetStb(cmdResetStb),
    .status     (status),
    .strobe     (strobe),
    .coreReset  (coreReset),
    .powerDown  (powerDown),
    .resetPulse (resetPulse),
    .commReady  (commReady)
  );

  assign loadDefaults = resetPulse;
  assign convRestart  = resetPulse;

endmodule

// File: rtl/pwr_rst_seq_chk.sv
module pwr_rst_seq_chk #(
  parameter int NUM_SUPPLY = 3
) (
  input logic                  clk,
  input logic [NUM_SUPPLY-1:0] supplyOk,
  input logic                  cmdResetStb,
  input logic                  coreReset,
  input logic                  powerDown,
  input logic                  loadDefaults,
  input logic                  commReady
);

  // R5
  pd_holds_reset_chk: assert property (@(posedge clk) disable iff (!(&supplyOk))
    powerDown |-> (coreReset && !commReady));

  // R10
  ready_no_reset_chk: assert property (@(posedge clk) disable iff (!(&supplyOk))
    commReady |-> !coreReset);

  // R6
  pd_exit_load_chk: assert property (@(posedge clk) disable iff (!(&supplyOk))
    $fell(powerDown) |-> loadDefaults);

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!(&supplyOk))
    loadDefaults |=> !loadDefaults);

  // R7
  cmd_drops_ready_chk: assert property (@(posedge clk) disable iff (!(&supplyOk))
    (commReady && cmdResetStb) |=> !commReady);

endmodule

bind pwr_rst_seq pwr_rst_seq_chk #(.NUM_SUPPLY(NUM_SUPPLY)) i_chk (
  .clk         (clk),
  .supplyOk    (supplyOk),
  .cmdResetStb (cmdResetStb),
  .coreReset   (coreReset),
  .powerDown   (powerDown),
  .loadDefaults(loadDefaults),
  .commReady   (commReady)
);

// File: tb/test_pwr_rst_seq.sv
`timescale 1ns/1ps
module test_pwr_rst_seq;

  localparam int NS    = 3;
  localparam int PDL   = 64;
  localparam int PDW   = 48;
  localparam int PORW  = 32;
  localparam int RMIN  = 4;
  localparam int RWAIT = 8;

  typedef struct {
    int    cycles;
    string req;
  } expItem_t;

  logic          clk = 1'b0;
  logic          resetPinN = 1'b1;
  logic [NS-1:0] supplyOk = '0;
  logic          cmdResetStb = 1'b0;
  logic          coreReset, powerDown, loadDefaults, convRestart, commReady;

  int       nChecks = 0;
  int       nBad = 0;
  bit       finished = 1'b0;
  expItem_t expQ[$];
  expItem_t cur;
  bit       measuring = 1'b0;
  int       elapsed = 0;

  always #2.5 clk = ~clk;

  pwr_rst_seq #(
    .NUM_SUPPLY(NS), .RST_MIN_LOW(RMIN), .PD_LOW(PDL),
    .RST_WAIT(RWAIT), .PD_WAIT(PDW), .POR_WAIT(PORW)
  ) i_pwr_rst_seq (
    .clk(clk), .resetPinN(resetPinN), .supplyOk(supplyOk),
    .cmdResetStb(cmdResetStb), .coreReset(coreReset), .powerDown(powerDown),
    .loadDefaults(loadDefaults), .convRestart(convRestart), .commReady(commReady)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectWait(input int cycles, input string req);
    expItem_t it;
    it.cycles = cycles;
    it.req    = req;
    expQ.push_back(it);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  endtask

  // monitor: pops one expected wait per defaults/restart pulse
  always @(negedge clk) begin
    if (loadDefaults === 1'b1) begin
      check(convRestart === 1'b1, "R9 restart with load", int'(convRestart), 1);
      if (expQ.size() == 0) begin
        check(1'b0, "R4 R8 unexpected pulse", 1, 0);
      end else begin
        cur       = expQ.pop_front();
        measuring = 1'b1;
        elapsed   = 0;
      end
    end
    if (measuring) begin
      if (commReady === 1'b1) begin
        check(elapsed == cur.cycles, cur.req, elapsed, cur.cycles);
        measuring = 1'b0;
      end else begin
        elapsed++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    tick(5);
    // R1 reset state with no supplies
    check(coreReset === 1'b1, "R1 reset state coreReset", int'(coreReset), 1);
    check(commReady === 1'b0, "R1 reset state ready", int'(commReady), 0);
    check(powerDown === 1'b0, "R1 reset state powerDown", int'(powerDown), 0);

    // R1 supplies in arbitrary order
    supplyOk[0] = 1'b1; tick(3);
    supplyOk[2] = 1'b1; tick(3);
    check(commReady === 1'b0, "R1 partial supplies", int'(commReady), 0);
    expectWait(0, "R1 por pulse");
    supplyOk[1] = 1'b1;
    tick(PORW + 1);
    check(commReady === 1'b0, "R1 before count end", int'(commReady), 0);
    check(coreReset === 1'b1, "R1 reset held", int'(coreReset), 1);
    tick(2);
    check(commReady === 1'b1, "R1 ready after count", int'(commReady), 1);
    check(coreReset === 1'b0, "R1 reset released", int'(coreReset), 0);
    tick(4);

    // R4 pulse of 3 cycles is ignored
    resetPinN = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i == 3) resetPinN = 1'b1;
      tick(1);
      check(coreReset === 1'b0, "R4 no internal reset", int'(coreReset), 0);
    end
    tick(2);
    check(commReady === 1'b1, "R4 ready restored", int'(commReady), 1);

    // R3 pulse of exactly 4 cycles resets
    expectWait(RWAIT, "R3 reset wait");
    resetPinN = 1'b0; tick(RMIN);
    resetPinN = 1'b1; tick(20);
    check(commReady === 1'b1, "R3 ready after reset", int'(commReady), 1);

    // R7 command reset
    expectWait(RWAIT, "R7 command wait");
    cmdResetStb = 1'b1; tick(1);
    cmdResetStb = 1'b0;
    check(commReady === 1'b0, "R7 ready drops", int'(commReady), 0);
    tick(20);

    // R5 hold just under threshold is a plain reset
    expectWait(RWAIT, "R5 near threshold");
    resetPinN = 1'b0;
    for (int i = 0; i < PDL - 2; i++) begin
      tick(1);
      if (powerDown !== 1'b0) check(1'b0, "R5 early powerDown", int'(powerDown), 0);
    end
    resetPinN = 1'b1; tick(20);
    check(powerDown === 1'b0, "R5 no powerDown", int'(powerDown), 0);
    check(commReady === 1'b1, "R5 ready after short hold", int'(commReady), 1);

    // R5 long hold enters power-down
    resetPinN = 1'b0; tick(PDL + 8);
    check(powerDown === 1'b1, "R5 powerDown", int'(powerDown), 1);
    check(coreReset === 1'b1, "R5 reset in powerDown", int'(coreReset), 1);
    check(commReady === 1'b0, "R5 not ready", int'(commReady), 0);

    // R8 command ignored in power-down
    cmdResetStb = 1'b1; tick(1);
    cmdResetStb = 1'b0; tick(5);
    check(powerDown === 1'b1, "R8 powerDown kept", int'(powerDown), 1);

    // R6 exit power-down
    expectWait(PDW, "R6 exit wait");
    resetPinN = 1'b1; tick(4);
    check(powerDown === 1'b0, "R6 powerDown off", int'(powerDown), 0);
    tick(PDW + 10);
    check(commReady === 1'b1, "R6 ready", int'(commReady), 1);

    // R2 supply drop
    supplyOk[1] = 1'b0;
    #1;
    check(coreReset === 1'b1, "R2 immediate reset", int'(coreReset), 1);
    check(commReady === 1'b0, "R2 immediate not ready", int'(commReady), 0);
    tick(3);
    expectWait(0, "R2 recount pulse");
    supplyOk[1] = 1'b1;
    tick(PORW + 1);
    check(commReady === 1'b0, "R2 recount running", int'(commReady), 0);
    tick(2);
    check(commReady === 1'b1, "R2 recount done", int'(commReady), 1);
    tick(4);

    check(expQ.size() == 0 && !measuring, "R9 all pulses seen", expQ.size(), 0);
    summary();
  end

endmodule